// File: doc/BRIEF.md
# Page-Buffered Serial Flash Command Sequencer

This block is an SPI master that drives a serial flash built from 264-byte pages and one 264-byte on-chip SRAM buffer. A client issues one command on a small command port: read a page straight from main memory, copy a page into the buffer, write bytes into the buffer, program the buffer into a page, or read the status register. The sequencer sends the opcode and address bytes, adds dummy bytes where the command needs them, and then moves data bytes. Incoming bytes leave on a valid-pulse stream. Outgoing bytes enter on a valid/ready stream.

The two commands that start an internal flash operation (page-to-buffer copy and buffer program) are not finished when their last byte has been shifted out. The sequencer releases chip select and then reads the status register in fresh chip-select frames until the device reports ready. Only then does it signal completion. The client therefore sees one command, one `busy` window and one `done` pulse for each flash operation. It never has to poll the flash itself.

Top module: `pgflash_seq`

## Requirements
- R1: While reset is held and right after it is released, `spi_cs_n` is 1, and `spi_sck`, `cmd_busy`, `cmd_done`, `rd_valid` and `wr_ready` are all 0.
- R2: The SPI link uses mode 0. SCK idles low and is low whenever chip select is high. MOSI changes only while SCK is low. MISO is sampled on the rising SCK edge. Every byte goes most significant bit first.
- R3: The first byte of each frame is the opcode. The `cmd_op` codes are: 0 = direct page read (0x52), 1 = page-to-buffer copy (0x53), 2 = buffer write (0x84), 3 = buffer program (0x83), 4 = status read (0x57).
- R4: Every command except status read sends three address bytes after the opcode, MSB first. Their value is `page*512 + offset`. The copy and program commands send offset 0. Buffer write sends page 0.
- R5: A direct page read sends 4 dummy bytes after the address and then clocks in `cmd_len` bytes. Each byte comes out on `rd_data` with a one-cycle `rd_valid` pulse, in the order received.
- R6: Buffer write sends `cmd_len` bytes taken from the write stream. A byte is taken in a cycle where `wr_valid` and `wr_ready` are both 1. While no byte is offered, SCK stays stopped.
- R7: After a copy or program command, chip select goes high. The block then repeats a two-byte frame (0x57, then one status byte read back) until a status byte has bit 7 set. `cmd_done` comes only after that frame.
- R8: A status-read command runs one frame of 0x57 plus one byte read back. The status byte is delivered on the read stream.
- R9: Between any two frames, chip select stays high for at least 2×`HALF_DIV` clock cycles, which is one SCK period.
- R10: `cmd_start` has no effect while `cmd_busy` is 1, and no effect when `cmd_op` is 5, 6 or 7.
- R11: A direct page read or buffer write with `cmd_len` = 0 sends only its header and dummy bytes and transfers no data byte.
- R12: `cmd_busy` is 1 from the cycle after a start is accepted until the command ends. `cmd_done` is then a single-cycle pulse, given with `cmd_busy` already 0 and chip select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_op | input | 3 | Command code (0..4) |
| cmd_page | input | PAGE_W | Flash page number |
| cmd_offset | input | OFF_W | Byte offset within a page or the buffer |
| cmd_len | input | LEN_W | Number of data bytes for read or buffer write |
| cmd_start | input | 1 | Start request, taken when idle |
| cmd_busy | output | 1 | Command in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| wr_data | input | 8 | Byte offered for buffer write |
| wr_valid | input | 1 | `wr_data` is valid |
| wr_ready | output | 1 | Sequencer takes `wr_data` this cycle |
| rd_data | output | 8 | Byte read from the flash |
| rd_valid | output | 1 | `rd_data` valid pulse |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The assertions rely on the client holding `cmd_len` within one page (0..264). They also rely on the flash driving MISO only in response to falling SCK edges or the fall of chip select, so MISO is steady at each rising edge. The stimulus keeps every length at 264 or below. The flash model in the bench changes MISO only on those two events. The write stream is the only input whose timing the bench varies: `wr_valid` is withdrawn on a fixed pattern of cycles so that the sequencer has to wait in the middle of a frame.

// File: rtl/pgflash_pkg.sv
package pgflash_pkg;

   typedef enum logic [2:0] {
      OP_RDPAGE = 3'd0,
      OP_LOAD   = 3'd1,
      OP_BUFWR  = 3'd2,
      OP_PROG   = 3'd3,
      OP_STAT   = 3'd4
   } op_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_NEXT,
      S_SHIFT,
      S_GAP
   } st_e;

   typedef enum logic [2:0] {
      PH_HDR,
      PH_DUMMY,
      PH_DATA,
      PH_PHDR,
      PH_PRD
   } ph_e;

   localparam logic [7:0] STATUS_OPC = 8'h57;

   function automatic logic [7:0] opcode_of(op_e op);
      case (op)
         OP_RDPAGE: return 8'h52;
         OP_LOAD:   return 8'h53;
         OP_BUFWR:  return 8'h84;
         OP_PROG:   return 8'h83;
         default:   return STATUS_OPC;
      endcase
   endfunction

endpackage

// File: rtl/pgflash_hdr.sv
module pgflash_hdr
   import pgflash_pkg::*;
#(
   parameter int PAGE_W = 10,
   parameter int OFF_W  = 9
) (
   input  op_e               op,
   input  logic [PAGE_W-1:0] page,
   input  logic [OFF_W-1:0]  off,
   input  logic [1:0]        idx,
   output logic [7:0]        hbyte
);
   localparam int ADDR_W = 24;

   if (PAGE_W + OFF_W > ADDR_W) begin : g_bad_addr
      $error("page and offset fields exceed the 24-bit address");
   end

   logic [ADDR_W-1:0] addr;

   always_comb begin
      case (op)
         OP_RDPAGE:       addr = ADDR_W'({page, off});
         OP_LOAD, OP_PROG: addr = ADDR_W'({page, {OFF_W{1'b0}}});
         OP_BUFWR:        addr = ADDR_W'(off);
         default:         addr = '0;
      endcase
   end

   always_comb begin
      case (idx)
         2'd0:    hbyte = opcode_of(op);
         2'd1:    hbyte = addr[23:16];
         2'd2:    hbyte = addr[15:8];
         default: hbyte = addr[7:0];
      endcase
   end
endmodule

// File: rtl/pgflash_shift.sv
module pgflash_shift #(
   parameter int HALF_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] tx,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       done,
   output logic [7:0] rx
);
   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end

   logic       active;
   logic       tick;
   logic [3:0] edges;
   logic [7:0] tsr;
   logic [7:0] rsr;
   logic       sck_q;

   if (HALF_DIV == 1) begin : g_fast
      assign tick = 1'b1;
   end else begin : g_div
      localparam int DW = $clog2(HALF_DIV);
      logic [DW-1:0] dcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  dcnt <= '0;
         else if (!active || tick)    dcnt <= '0;
         else                         dcnt <= dcnt + DW'(1);
      end
      assign tick = active && (dcnt == DW'(HALF_DIV - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         edges  <= '0;
         tsr    <= '0;
         rsr    <= '0;
         sck_q  <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go && !active) begin
            active <= 1'b1;
            tsr    <= tx;
            edges  <= '0;
            sck_q  <= 1'b0;
         end else if (active && tick) begin
            sck_q <= ~sck_q;
            edges <= edges + 4'd1;
            if (!sck_q) rsr <= {rsr[6:0], miso};
            else        tsr <= {tsr[6:0], 1'b0};
            if (edges == 4'd15) begin
               active <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   assign sck  = sck_q;
   assign mosi = tsr[7];
   assign rx   = rsr;

   // R2
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));

   // R2
   sck_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !sck);
endmodule

// File: rtl/pgflash_seq.sv
module pgflash_seq
   import pgflash_pkg::*;
#(
   parameter int HALF_DIV = 2,
   parameter int PAGE_W   = 10,
   parameter int OFF_W    = 9,
   parameter int LEN_W    = 9,
   parameter int DUMMY_N  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd_op,
   input  logic [PAGE_W-1:0] cmd_page,
   input  logic [OFF_W-1:0]  cmd_offset,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic              cmd_start,
   output logic              cmd_busy,
   output logic              cmd_done,
   input  logic [7:0]        wr_data,
   input  logic              wr_valid,
   output logic              wr_ready,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              spi_cs_n,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   localparam int GAP_CYC = 2 * HALF_DIV;
   localparam int GAP_W   = $clog2(GAP_CYC + 1);
   localparam int DUM_W   = $clog2(DUMMY_N + 1);
   localparam int CNT_A   = (LEN_W > DUM_W) ? LEN_W : DUM_W;
   localparam int CNT_W   = (CNT_A > 3) ? CNT_A : 3;

   if (DUMMY_N < 1) begin : g_bad_dummy
      $error("DUMMY_N must be at least 1");
   end

   st_e               st;
   ph_e               ph;
   op_e               op_q;
   logic [PAGE_W-1:0] page_q;
   logic [OFF_W-1:0]  off_q;
   logic [LEN_W-1:0]  len_q;
   logic [CNT_W-1:0]  bcnt;
   logic [CNT_W-1:0]  dlen;
   logic [CNT_W-1:0]  hdr_n;
   logic [GAP_W-1:0]  gcnt;
   logic              poll_next;
   logic              cs_q, go_q, done_q, rdv_q;
   logic [7:0]        tx_q, rdd_q, hdr_byte, sh_rx;
   logic              sh_done;
   logic              is_wr, op_ok;

   assign op_ok = (cmd_op <= 3'd4);
   assign is_wr = (op_q == OP_BUFWR);
   assign hdr_n = (op_q == OP_STAT) ? CNT_W'(1) : CNT_W'(4);

   always_comb begin
      case (op_q)
         OP_RDPAGE, OP_BUFWR: dlen = CNT_W'(len_q);
         OP_STAT:             dlen = CNT_W'(1);
         default:             dlen = '0;
      endcase
   end

   pgflash_hdr #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_hdr (
      .op(op_q), .page(page_q), .off(off_q), .idx(bcnt[1:0]), .hbyte(hdr_byte)
   );

   pgflash_shift #(.HALF_DIV(HALF_DIV)) u_shift (
      .clk(clk), .rst_n(rst_n), .go(go_q), .tx(tx_q), .miso(spi_miso),
      .sck(spi_sck), .mosi(spi_mosi), .done(sh_done), .rx(sh_rx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         ph        <= PH_HDR;
         op_q      <= OP_STAT;
         page_q    <= '0;
         off_q     <= '0;
         len_q     <= '0;
         bcnt      <= '0;
         gcnt      <= '0;
         poll_next <= 1'b0;
         cs_q      <= 1'b1;
         go_q      <= 1'b0;
         tx_q      <= '0;
         done_q    <= 1'b0;
         rdv_q     <= 1'b0;
         rdd_q     <= '0;
      end else begin
         go_q   <= 1'b0;
         done_q <= 1'b0;
         rdv_q  <= 1'b0;
         case (st)
            S_IDLE: if (cmd_start && op_ok) begin
               op_q   <= op_e'(cmd_op);
               page_q <= cmd_page;
               off_q  <= cmd_offset;
               len_q  <= cmd_len;
               cs_q   <= 1'b0;
               ph     <= PH_HDR;
               bcnt   <= '0;
               st     <= S_NEXT;
            end
            S_NEXT: case (ph)
               PH_HDR: if (bcnt < hdr_n) begin
                  tx_q <= hdr_byte; go_q <= 1'b1; st <= S_SHIFT;
               end else if (op_q == OP_RDPAGE) begin
                  ph <= PH_DUMMY; bcnt <= '0;
               end else if (op_q == OP_LOAD || op_q == OP_PROG) begin
                  cs_q <= 1'b1; poll_next <= 1'b1; gcnt <= '0; st <= S_GAP;
               end else begin
                  ph <= PH_DATA; bcnt <= '0;
               end
               PH_DUMMY: if (bcnt < CNT_W'(DUMMY_N)) begin
                  tx_q <= 8'h00; go_q <= 1'b1; st <= S_SHIFT;
               end else begin
                  ph <= PH_DATA; bcnt <= '0;
               end
               PH_DATA: if (bcnt < dlen) begin
                  if (!is_wr) begin
                     tx_q <= 8'h00; go_q <= 1'b1; st <= S_SHIFT;
                  end else if (wr_valid) begin
                     tx_q <= wr_data; go_q <= 1'b1; st <= S_SHIFT;
                  end
               end else begin
                  cs_q <= 1'b1; poll_next <= 1'b0; gcnt <= '0; st <= S_GAP;
               end
               PH_PHDR: if (bcnt == '0) begin
                  tx_q <= STATUS_OPC; go_q <= 1'b1; st <= S_SHIFT;
               end else begin
                  ph <= PH_PRD; bcnt <= '0;
               end
               PH_PRD: if (bcnt == '0) begin
                  tx_q <= 8'h00; go_q <= 1'b1; st <= S_SHIFT;
               end else begin
                  cs_q <= 1'b1; poll_next <= ~sh_rx[7]; gcnt <= '0; st <= S_GAP;
               end
               default: st <= S_IDLE;
            endcase
            S_SHIFT: if (sh_done) begin
               bcnt <= bcnt + CNT_W'(1);
               st   <= S_NEXT;
               if (ph == PH_DATA && !is_wr) begin
                  rdd_q <= sh_rx; rdv_q <= 1'b1;
               end
            end
            S_GAP: if (gcnt == GAP_W'(GAP_CYC - 1)) begin
               if (poll_next) begin
                  cs_q <= 1'b0; ph <= PH_PHDR; bcnt <= '0; st <= S_NEXT;
               end else begin
                  done_q <= 1'b1; st <= S_IDLE;
               end
            end else begin
               gcnt <= gcnt + GAP_W'(1);
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign cmd_busy = (st != S_IDLE);
   assign cmd_done = done_q;
   assign rd_data  = rdd_q;
   assign rd_valid = rdv_q;
   assign spi_cs_n = cs_q;
   assign wr_ready = (st == S_NEXT) && (ph == PH_DATA) && is_wr && (bcnt < dlen);

   // high-time counter of chip select, saturating, for the frame spacing check
   logic [GAP_W-1:0] hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              hi_cnt <= GAP_W'(GAP_CYC);
      else if (!spi_cs_n)                      hi_cnt <= '0;
      else if (hi_cnt != GAP_W'(GAP_CYC))      hi_cnt <= hi_cnt + GAP_W'(1);
   end

   // R9
   cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> (hi_cnt == GAP_W'(GAP_CYC)));

   // R2
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |=> !cmd_done);

   // R12
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> (!cmd_busy && spi_cs_n));

   // R5
   rd_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !spi_cs_n);

   // R6
   wr_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |-> (!spi_cs_n && !spi_sck));
endmodule

// File: tb/pgflash_seq_bench.sv
module pgflash_seq_bench;
   localparam int HALF = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [9:0] cmd_page = '0;
   logic [8:0] cmd_offset = '0;
   logic [8:0] cmd_len = '0;
   logic       cmd_start = 1'b0;
   logic       cmd_busy, cmd_done;
   logic [7:0] wr_data = '0;
   logic       wr_valid = 1'b0;
   logic       wr_ready;
   logic [7:0] rd_data;
   logic       rd_valid;
   logic       spi_cs_n, spi_sck, spi_mosi;
   logic       spi_miso = 1'b1;

   always #4 clk = ~clk;

   pgflash_seq #(.HALF_DIV(HALF)) u_pgflash_seq (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_page(cmd_page),
      .cmd_offset(cmd_offset), .cmd_len(cmd_len), .cmd_start(cmd_start),
      .cmd_busy(cmd_busy), .cmd_done(cmd_done), .wr_data(wr_data),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
      .rd_valid(rd_valid), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   // scoreboard queues
   logic [7:0] exp_mosi_q[$];
   logic [7:0] exp_rd_q[$];
   int         exp_len_q[$];

   int d_tot = 0, d_bad = 0, s_tot = 0, s_bad = 0, m_tot = 0, m_bad = 0, w_bad = 0;

   task automatic chk(inout int t, inout int b, input bit ok, input string tag,
                      input int act, input int exp);
      t++;
      if (!ok) begin
         b++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(int page, int off);
      return 8'((page * 3 + off * 5 + 1) & 255);
   endfunction

   // flash model: settings written only by the driver
   int busy_cfg = 0;

   int         bitc, bidx, fbytes, poll_idx, frame_cnt = 0, stat_frames = 0;
   bit         in_frame = 0;
   logic [7:0] in_sr, out_sr;
   logic [7:0] fbuf[4];
   realtime    last_rise = -1.0;
   int         min_gap = 1000000;

   always @(posedge spi_cs_n, negedge spi_cs_n, posedge spi_sck, negedge spi_sck) begin
      if (spi_cs_n) begin
         if (in_frame) begin
            in_frame = 0;
            frame_cnt++;
            if (fbytes >= 1 && fbuf[0] == 8'h57) stat_frames++;
            if (exp_len_q.size() == 0)
               chk(s_tot, s_bad, 0, "R3 unexpected frame", fbytes, 0);
            else begin
               int e;
               e = exp_len_q.pop_front();
               chk(s_tot, s_bad, fbytes == e, "R5 frame length", fbytes, e);
            end
            last_rise = $realtime;
         end
      end else if (!in_frame) begin
         in_frame = 1;
         bitc = 0; bidx = 0; fbytes = 0;
         out_sr = 8'hFF;
         spi_miso = out_sr[7];
         if (last_rise >= 0.0) begin
            int g;
            g = int'(($realtime - last_rise) / 8.0);
            if (g < min_gap) min_gap = g;
         end
      end else if (spi_sck) begin
         in_sr = {in_sr[6:0], spi_mosi};
         bitc++;
      end else begin
         if (bitc == 8) begin
            if (bidx < 4) fbuf[bidx] = in_sr;
            fbytes++;
            if (exp_mosi_q.size() == 0)
               chk(s_tot, s_bad, 0, "R2 extra MOSI byte", in_sr, 0);
            else begin
               logic [7:0] e;
               e = exp_mosi_q.pop_front();
               chk(s_tot, s_bad, in_sr == e, "R4 MOSI byte", in_sr, e);
            end
            if (bidx == 0 && in_sr != 8'h57) poll_idx = 0;
            bitc = 0;
            bidx++;
            if (fbuf[0] == 8'h57 && bidx == 1) begin
               out_sr = (poll_idx < busy_cfg) ? 8'h1C : 8'h9C;
               poll_idx++;
            end else if (fbuf[0] == 8'h52 && bidx >= 8) begin
               int a;
               a = {8'h00, fbuf[1], fbuf[2], fbuf[3]};
               out_sr = pat(a >> 9, (a & 511) + bidx - 8);
            end else out_sr = 8'hA5;
         end else out_sr = {out_sr[6:0], 1'b0};
         spi_miso = out_sr[7];
      end
   end

   // write-stream feeder with stalls
   logic [7:0] wr_src[16];
   int wr_n = 0, wr_gen = 0;
   int f_gen = 0, f_idx = 0, f_cyc = 0;
   bit f_acc = 0;
   always @(negedge clk) begin
      f_cyc++;
      if (f_gen != wr_gen) begin f_gen = wr_gen; f_idx = 0; f_acc = 0; end
      if (f_acc) begin f_acc = 0; f_idx++; end
      wr_valid = (f_idx < wr_n) && ((f_cyc % 5) >= 2);
      wr_data  = (f_idx < 16) ? wr_src[f_idx] : 8'h00;
      if (wr_valid && wr_ready) f_acc = 1;
   end

   // monitor: read stream and completion pulses
   int  done_cnt = 0;
   bit  prev_done = 0;
   always @(negedge clk) begin
      if (rd_valid) begin
         if (exp_rd_q.size() == 0)
            chk(m_tot, m_bad, 0, "R5 unexpected read byte", rd_data, 0);
         else begin
            logic [7:0] e;
            e = exp_rd_q.pop_front();
            chk(m_tot, m_bad, rd_data == e, "R5 read byte", rd_data, e);
         end
      end
      if (prev_done) chk(m_tot, m_bad, !cmd_done, "R12 done width", cmd_done, 0);
      if (cmd_done) begin
         done_cnt++;
         chk(m_tot, m_bad, !cmd_busy && spi_cs_n, "R12 idle at done", cmd_busy, 0);
      end
      prev_done = cmd_done;
   end

   // watchdog
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         w_bad = 1;
         $display("FAIL watchdog act=%0d exp=0", wd);
         $display("test done: total=%0d bad=%0d", d_tot + s_tot + m_tot + 1,
                  d_bad + s_bad + m_bad + 1);
         $finish;
      end
   end

   task automatic push_hdr(input logic [7:0] opc, input int addr);
      exp_mosi_q.push_back(opc);
      exp_mosi_q.push_back(8'((addr >> 16) & 255));
      exp_mosi_q.push_back(8'((addr >> 8) & 255));
      exp_mosi_q.push_back(8'(addr & 255));
   endtask

   task automatic run(input int op, input int page, input int off, input int len,
                      input int busy, input bit poke, input string tag);
      int d0;
      busy_cfg = busy;
      case (op)
         0: begin
            push_hdr(8'h52, (page << 9) | off);
            for (int k = 0; k < 4 + len; k++) exp_mosi_q.push_back(8'h00);
            for (int k = 0; k < len; k++) exp_rd_q.push_back(pat(page, off + k));
            exp_len_q.push_back(8 + len);
         end
         1, 3: begin
            push_hdr(op == 1 ? 8'h53 : 8'h83, page << 9);
            exp_len_q.push_back(4);
            for (int k = 0; k <= busy; k++) begin
               exp_mosi_q.push_back(8'h57); exp_mosi_q.push_back(8'h00);
               exp_len_q.push_back(2);
            end
         end
         2: begin
            push_hdr(8'h84, off);
            for (int k = 0; k < len; k++) exp_mosi_q.push_back(wr_src[k]);
            exp_len_q.push_back(4 + len);
            wr_n = len;
            wr_gen++;
         end
         default: begin
            exp_mosi_q.push_back(8'h57); exp_mosi_q.push_back(8'h00);
            exp_rd_q.push_back(8'h9C);
            exp_len_q.push_back(2);
         end
      endcase
      d0 = done_cnt;
      @(negedge clk);
      cmd_op = 3'(op); cmd_page = 10'(page); cmd_offset = 9'(off); cmd_len = 9'(len);
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      chk(d_tot, d_bad, cmd_busy, {tag, " R12 busy after start"}, cmd_busy, 1);
      if (poke) begin
         repeat (20) @(negedge clk);
         cmd_op = 3'd4; cmd_start = 1'b1;
         @(negedge clk);
         cmd_start = 1'b0;
      end
      for (int i = 0; i < 20000 && done_cnt == d0; i++) @(negedge clk);
      chk(d_tot, d_bad, done_cnt == d0 + 1, {tag, " done seen"}, done_cnt - d0, 1);
      repeat (2) @(negedge clk);
      chk(d_tot, d_bad, exp_mosi_q.size() == 0 && exp_len_q.size() == 0 &&
          exp_rd_q.size() == 0, {tag, " scoreboard drained"},
          exp_mosi_q.size() + exp_len_q.size() + exp_rd_q.size(), 0);
   endtask

   initial begin
      int sf, fc, dc;
      repeat (3) @(negedge clk);
      // R1
      chk(d_tot, d_bad, spi_cs_n && !spi_sck && !cmd_busy && !cmd_done && !rd_valid &&
          !wr_ready, "R1 reset outputs", {spi_cs_n, spi_sck, cmd_busy, cmd_done}, 4'b1000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(d_tot, d_bad, spi_cs_n && !spi_sck && !cmd_busy && !cmd_done,
          "R1 after release", {spi_cs_n, spi_sck, cmd_busy}, 3'b100);

      run(4, 0, 0, 0, 0, 0, "R8 status read R3");
      run(0, 5, 3, 6, 0, 0, "R5 page read R4");
      run(0, 600, 260, 4, 0, 0, "R5 page read high page");
      run(0, 9, 0, 0, 0, 0, "R11 read len 0");
      wr_src[0] = 8'hA1; wr_src[1] = 8'hB2; wr_src[2] = 8'hC3; wr_src[3] = 8'h5E;
      run(2, 7, 261, 4, 0, 0, "R6 buffer write R4");
      run(2, 3, 17, 0, 0, 0, "R11 write len 0");

      sf = stat_frames;
      run(1, 511, 100, 0, 3, 1, "R7 copy with poll R10");
      chk(d_tot, d_bad, stat_frames - sf == 4, "R7 poll frames", stat_frames - sf, 4);
      sf = stat_frames;
      run(3, 300, 7, 0, 0, 0, "R7 program ready");
      chk(d_tot, d_bad, stat_frames - sf == 1, "R7 single poll", stat_frames - sf, 1);

      // R10 invalid opcode
      fc = frame_cnt; dc = done_cnt;
      @(negedge clk);
      cmd_op = 3'd6; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      chk(d_tot, d_bad, !cmd_busy, "R10 invalid op busy", cmd_busy, 0);
      repeat (60) @(negedge clk);
      chk(d_tot, d_bad, frame_cnt == fc && done_cnt == dc && spi_cs_n,
          "R10 invalid op no frame", frame_cnt - fc, 0);

      // R9
      chk(d_tot, d_bad, min_gap >= 2 * HALF, "R9 frame spacing", min_gap, 2 * HALF);

      $display("test done: total=%0d bad=%0d", d_tot + s_tot + m_tot,
               d_bad + s_bad + m_bad + w_bad);
      $finish;
   end
endmodule